// File: doc/BRIEF.md
# Processor mode and interrupt-mask status register

This block holds the privilege state of a small 32-bit CPU core: a two-bit operating mode and two interrupt-disable bits. One bit masks ordinary interrupts (I). The other masks fast interrupts (F). The block has two update paths. When trap logic takes an exception, the block changes to the mode for that exception and raises the matching mask bits. Privileged software can also load all four bits from the ALU result bus.

The core uses a two-phase clock. Here it is modelled as a single clock `clk` and a phase input `phase_i`, which is low in phase 1 and high in phase 2. Exception loads act only in phase 1 and software writes act only in phase 2, so the two paths never update the register in the same cycle.

The exception code from the trap logic does not use the same encoding as the mode field, so it is remapped before it is stored. A flag output tells the rest of the core when the current mode is user mode.

Top module: `mode_mask_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, the mode is supervisor (`2'b11`), I = 1, F = 1 and `user_o` = 0.
- R2: The mode field uses this encoding: 00 = user, 01 = fast interrupt, 10 = interrupt, 11 = supervisor. An exception load stores the mode from the exception code `exc_code_i` as follows:

  | `exc_code_i` | Meaning | Mode stored |
  |---|---|---|
  | 01 | fast interrupt | 01 |
  | 10 | interrupt | 10 |
  | 11 | reset | 11 |
  | 00 | any other trap | 11 |

- R3: Every exception load sets I to 1.
- R4: An exception load sets F to 1 when `exc_code_i[0]` is 1. When `exc_code_i[0]` is 0, F keeps its value.
- R5: An exception request in phase 1 while `abort_i` is high leaves all four bits unchanged.
- R6: An exception request while `phase_i` is 1 (phase 2) is ignored.
- R7: A write request in phase 2 outside user mode loads I from `alu_bus_i[27]`, F from `alu_bus_i[26]` and the mode from `alu_bus_i[1:0]` on that clock edge.
- R8: A write request while the stored mode is user (00) is ignored.
- R9: A write request while `phase_i` is 0 (phase 1) is ignored.
- R10: `user_o` is 1 exactly when the stored mode is 00. It follows the registered value, so a write that enters user mode completes, and the write after it is blocked.
- R11: With no valid request, all four bits hold their value from one cycle to the next.
- R12: Exception loads are allowed in every mode, including user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 1 | Clock phase: 0 = phase 1, 1 = phase 2 |
| exc_req_i | input | 1 | Exception bank-enable request from trap logic |
| abort_i | input | 1 | Abort; suppresses the exception load |
| exc_code_i | input | 2 | Exception code {bank1, bank0} |
| wr_req_i | input | 1 | Write-flags request from instruction decode |
| alu_bus_i | input | 32 | ALU result bus used as the write source |
| mode_o | output | 2 | Current mode |
| irq_mask_o | output | 1 | I bit (interrupts disabled) |
| fiq_mask_o | output | 1 | F bit (fast interrupts disabled) |
| user_o | output | 1 | High when the current mode is user |

## Verification
The assertions assume that `phase_i` alternates on every clock once reset is released. They also assume that the trap logic does not raise requests on its own during reset. The bench therefore owns the phase: it flips `phase_i` once per driven cycle and inserts idle cycles to reach the phase each case needs.

Some cases deliberately place a request in the wrong phase. These check that requests arriving at the wrong time have no effect. The bench never changes the order in which the phases alternate, so the assertions' assumption about the phase still holds throughout.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    EXC_OTHER = 2'b00,
    EXC_FIQ   = 2'b01,
    EXC_IRQ   = 2'b10,
    EXC_RST   = 2'b11
  } exc_e;

  typedef struct packed {
    mode_e mode;
    logic  imask;
    logic  fmask;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{mode: MODE_SVC, imask: 1'b1, fmask: 1'b1};

endpackage

// File: rtl/mmr_exc_path.sv
module mmr_exc_path
  import mmr_pkg::*;
(
  input  flags_t     cur_i,
  input  logic       phase_i,
  input  logic       req_i,
  input  logic       abort_i,
  input  logic [1:0] code_i,
  output logic       load_o,
  output flags_t     nxt_o
);

  exc_e  code;
  mode_e new_mode;

  assign code = exc_e'(code_i);

  // Trap code to mode: reset and "other" both land in supervisor.
  always_comb begin
    unique case (code)
      EXC_FIQ: new_mode = MODE_FIQ;
      EXC_IRQ: new_mode = MODE_IRQ;
      default: new_mode = MODE_SVC;
    endcase
  end

  // Phase 1 only, and never while an abort is pending.
  assign load_o = req_i && !abort_i && !phase_i;

  always_comb begin
    nxt_o       = cur_i;
    nxt_o.mode  = new_mode;
    nxt_o.imask = 1'b1;
    nxt_o.fmask = cur_i.fmask | code_i[0];
  end

endmodule

// File: rtl/mmr_sw_path.sv
module mmr_sw_path
  import mmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int I_BIT    = 27,
  parameter int F_BIT    = 26,
  parameter int MODE_LSB = 0
) (
  input  logic              is_user_i,
  input  logic              phase_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              load_o,
  output flags_t            nxt_o
);

  localparam int MODE_W = $bits(mode_e);

  logic unused_bus;

  // Phase 2 only, and refused while the registered mode is user.
  assign load_o = req_i && phase_i && !is_user_i;

  always_comb begin
    nxt_o.mode  = mode_e'(bus_i[MODE_LSB +: MODE_W]);
    nxt_o.imask = bus_i[I_BIT];
    nxt_o.fmask = bus_i[F_BIT];
  end

  assign unused_bus = ^bus_i;

endmodule

// File: rtl/mode_mask_reg.sv
module mode_mask_reg
  import mmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int I_BIT    = 27,
  parameter int F_BIT    = 26,
  parameter int MODE_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_i,
  input  logic              exc_req_i,
  input  logic              abort_i,
  input  logic [1:0]        exc_code_i,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] alu_bus_i,
  output logic [1:0]        mode_o,
  output logic              irq_mask_o,
  output logic              fiq_mask_o,
  output logic              user_o
);

  flags_t flags_q, flags_d;
  flags_t exc_nxt, sw_nxt;
  logic   exc_load, sw_load, is_user;

  assign is_user = (flags_q.mode == MODE_USR);

  mmr_exc_path u_exc (
    .cur_i   (flags_q),
    .phase_i (phase_i),
    .req_i   (exc_req_i),
    .abort_i (abort_i),
    .code_i  (exc_code_i),
    .load_o  (exc_load),
    .nxt_o   (exc_nxt)
  );

  mmr_sw_path #(
    .DATA_W   (DATA_W),
    .I_BIT    (I_BIT),
    .F_BIT    (F_BIT),
    .MODE_LSB (MODE_LSB)
  ) u_sw (
    .is_user_i (is_user),
    .phase_i   (phase_i),
    .req_i     (wr_req_i),
    .bus_i     (alu_bus_i),
    .load_o    (sw_load),
    .nxt_o     (sw_nxt)
  );

  // Next state: the phases keep the two loads apart; exception wins by order.
  always_comb begin
    flags_d = flags_q;
    if (exc_load)     flags_d = exc_nxt;
    else if (sw_load) flags_d = sw_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RESET;
    else        flags_q <= flags_d;
  end

  assign mode_o     = flags_q.mode;
  assign irq_mask_o = flags_q.imask;
  assign fiq_mask_o = flags_q.fmask;
  assign user_o     = is_user;

  // R3
  a_r3_exc_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && !abort_i && !phase_i) |=> irq_mask_o);

  // R4
  a_r4_fast_sets_f: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && !abort_i && !phase_i && exc_code_i[0]) |=> fiq_mask_o);

  // R2
  a_r2_other_to_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && !abort_i && !phase_i && exc_code_i == 2'b00) |=> mode_o == 2'b11);

  // R5
  a_r5_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_i && abort_i) |=> $stable({mode_o, irq_mask_o, fiq_mask_o}));

  // R8
  a_r8_user_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i && user_o) |=> $stable({mode_o, irq_mask_o, fiq_mask_o}));

  // R11
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && !wr_req_i) |=> $stable({mode_o, irq_mask_o, fiq_mask_o}));

endmodule

// File: tb/mode_mask_reg_tb.sv
module mode_mask_reg_tb;

  typedef struct {
    logic [1:0] mode;
    logic       i;
    logic       f;
    logic       usr;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        phase;
  logic        exc_req, abort, wr_req;
  logic [1:0]  code;
  logic [31:0] bus;
  logic [1:0]  mode;
  logic        imask, fmask, usr;

  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  logic [1:0] m_mode;
  logic       m_i, m_f;
  logic       ph;

  always #2.5 clk = ~clk;

  mode_mask_reg u_dut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .exc_req_i(exc_req),
    .abort_i(abort), .exc_code_i(code), .wr_req_i(wr_req), .alu_bus_i(bus),
    .mode_o(mode), .irq_mask_o(imask), .fiq_mask_o(fmask), .user_o(usr)
  );

  function automatic logic [31:0] mk_bus(logic [1:0] md, logic i, logic f);
    logic [31:0] b = 32'h5A5A_5A5C;
    b[27] = i; b[26] = f; b[1:0] = md;
    return b;
  endfunction

  // Driver: applies one cycle and pushes the expected post-edge state.
  task automatic cyc(logic e, logic a, logic [1:0] c, logic w, logic [31:0] b, string tag);
    exp_t x;
    @(negedge clk);
    phase = ph; exc_req = e; abort = a; code = c; wr_req = w; bus = b;
    if (!ph && e && !a) begin
      m_mode = (c == 2'b00) ? 2'b11 : c;
      m_i = 1'b1;
      m_f = m_f | c[0];
    end else if (ph && w && m_mode != 2'b00) begin
      m_mode = b[1:0]; m_i = b[27]; m_f = b[26];
    end
    x.mode = m_mode; x.i = m_i; x.f = m_f; x.usr = (m_mode == 2'b00); x.tag = tag;
    q.push_back(x);
    ph = ~ph;
  endtask

  task automatic idle(string tag);
    cyc(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, tag);
  endtask

  task automatic to_phase(logic p);
    if (ph != p) idle("R11 hold");
  endtask

  task automatic exc(logic [1:0] c, string tag);
    to_phase(1'b0); cyc(1'b1, 1'b0, c, 1'b0, 32'hFFFF_FFFF, tag);
  endtask

  task automatic wr(logic [1:0] md, logic i, logic f, string tag);
    to_phase(1'b1); cyc(1'b0, 1'b0, 2'b00, 1'b1, mk_bus(md, i, f), tag);
  endtask

  // Monitor: pops one expectation per clock and compares away from the edge.
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        x = q.pop_front();
        checks++;
        if (mode !== x.mode || imask !== x.i || fmask !== x.f || usr !== x.usr) begin
          errors++;
          $display("FAIL %s: got mode=%b I=%b F=%b user=%b, expected mode=%b I=%b F=%b user=%b",
                   x.tag, mode, imask, fmask, usr, x.mode, x.i, x.f, x.usr);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; phase = 1'b0; exc_req = 1'b0; abort = 1'b0;
    code = 2'b00; wr_req = 1'b0; bus = 32'h0;
    m_mode = 2'b11; m_i = 1'b1; m_f = 1'b1; ph = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (mode !== 2'b11 || imask !== 1'b1 || fmask !== 1'b1 || usr !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: got %b%b%b%b, expected 11110", mode, imask, fmask, usr);
    end
    @(negedge clk); rst_n = 1'b1;
    idle("R1 after release");
    idle("R11 hold");

    wr(2'b00, 1'b0, 1'b0, "R7 write to user");
    idle("R10 user flag");
    wr(2'b11, 1'b1, 1'b1, "R8 user write blocked");
    to_phase(1'b1); cyc(1'b1, 1'b0, 2'b10, 1'b0, 32'h0, "R6 exc in phase 2");
    to_phase(1'b0); cyc(1'b1, 1'b1, 2'b10, 1'b0, 32'h0, "R5 abort");
    exc(2'b10, "R2 R3 R4 R12 irq from user");
    to_phase(1'b0); cyc(1'b0, 1'b0, 2'b00, 1'b1, mk_bus(2'b01, 1'b0, 1'b0), "R9 write in phase 1");
    wr(2'b01, 1'b0, 1'b0, "R7 write fiq mode");
    exc(2'b00, "R2 R4 other to svc, F kept");
    wr(2'b10, 1'b0, 1'b0, "R7 clear masks");
    exc(2'b01, "R2 R4 fiq sets F");
    wr(2'b11, 1'b0, 1'b0, "R7 clear in svc");
    exc(2'b11, "R2 R4 reset code");
    for (int c = 0; c < 4; c++) begin
      wr(2'b00, 1'b0, 1'b0, "R10 back to user");
      exc(c[1:0], "R2 R3 R4 R12 code sweep");
      idle("R11 hold");
    end
    wr(2'b00, 1'b1, 1'b0, "R10 enter user");
    wr(2'b11, 1'b0, 1'b1, "R10 next write blocked");
    repeat (3) idle("R11 hold");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule